// File: doc/BRIEF.md
# Entropy Health Test and Seed Collector

This block sits between a noise source that delivers 4-bit samples with a valid strobe and a deterministic random bit generator that consumes full-size seeds. Every valid sample goes through two continuous health tests: a repetition count test that catches a stuck source, and an adaptive proportion test that catches a source biased towards one value within a fixed window. Both tests run from the first sample after reset and never stop.

After reset the block first qualifies the source over a startup run of samples. No sample of that run is kept. Once the run passes, the block packs the following samples into a seed register, most significant nibble first. It raises a ready flag when the seed is complete and holds it until the consumer acknowledges. Any health-test failure latches a permanent failure flag. From then on no seed is offered and the seed output reads as zero until the next reset. Reset also clears the stored seed.

Top module: `entropy_seed_collector`

## Requirements
- R1: While reset is held and right after it is released, `seed_ready_o`, `qualified_o` and `perm_fail_o` are 0 and `seed_o` is all zeros.
- R2: The repetition count test counts consecutive identical valid samples, with idle cycles not breaking the run. It fails on the valid sample that brings the run to RCT_CUTOFF (default 8), and `perm_fail_o` is 1 from the next cycle. A run of RCT_CUTOFF-1 does not fail.
- R3: The adaptive proportion test splits the valid samples into windows of APT_WINDOW (default 512), the first window starting at the first valid sample after reset. The first sample of a window is its reference value. The test fails on the sample that brings the count of the reference value in the window, the first sample included, to APT_CUTOFF (default 100). A window holding APT_CUTOFF-1 copies does not fail.
- R4: `qualified_o` rises in the cycle after the STARTUP_SAMPLES-th valid sample (default 1024) if no failure has occurred. It is 0 before that cycle. Samples of the startup run are never stored.
- R5: `perm_fail_o` stays at 1 until reset. While it is 1, `qualified_o` is 0.
- R6: While `perm_fail_o` is 1, `seed_ready_o` is 0 and `seed_o` is all zeros. This also holds when the failure strikes while a seed is waiting.
- R7: After qualification the next SEED_SAMPLES valid samples (default 640) are packed into `seed_o`, the first sample in bits [SEED_W-1:SEED_W-4] and the last in bits [3:0]. `seed_ready_o` rises in the cycle after the last of them has passed the health tests. `seed_o` reads zero whenever `seed_ready_o` is 0.
- R8: `seed_ready_o` and `seed_o` hold until a cycle with `seed_ack_i` high, and `seed_ready_o` is 0 in the cycle after it. Samples that arrive while `seed_ready_o` is 1, including the one in the acknowledge cycle, are health-tested but not stored. The next seed is built from the valid samples that follow.
- R9: Reset clears the stored seed, the failure flag and the qualification, and restarts both the startup run and the adaptive proportion windowing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Sample strobe |
| smp_i | input | SAMPLE_W (4) | Noise sample |
| seed_ack_i | input | 1 | Consumer takes the presented seed |
| seed_ready_o | output | 1 | A complete, tested seed is presented |
| seed_o | output | SAMPLE_W*SEED_SAMPLES (2560) | Seed, first sample in the top nibble; zero when not ready |
| qualified_o | output | 1 | Startup run passed and no failure seen |
| perm_fail_o | output | 1 | Sticky health-test failure |

## Verification
On every cycle the assertions check the following: the failure flag never clears, no seed is visible after a failure, a seed is presented only while the block is qualified, and a waiting seed holds still until it is acknowledged and drops right after. What only the scenarios can show is the counting. This covers the exact sample on which each test trips, the near-miss runs and windows one short of the cutoffs, the window alignment from reset, the length of the startup run, the nibble order in the seed, and the dropping of samples that arrive while a seed waits. A bench model of the tests follows every cycle of constrained-random traffic to confirm these.

// File: rtl/entropy_seed_collector.sv
module entropy_seed_collector #(
  parameter int SAMPLE_W        = 4,
  parameter int SEED_SAMPLES    = 640,
  parameter int STARTUP_SAMPLES = 1024,
  parameter int APT_WINDOW      = 512,
  parameter int RCT_CUTOFF      = 8,
  parameter int APT_CUTOFF      = 100
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               smp_valid_i,
  input  logic [SAMPLE_W-1:0]                smp_i,
  input  logic                               seed_ack_i,
  output logic                               seed_ready_o,
  output logic [SAMPLE_W*SEED_SAMPLES-1:0]   seed_o,
  output logic                               qualified_o,
  output logic                               perm_fail_o
);

  localparam int SEED_W = SAMPLE_W * SEED_SAMPLES;
  localparam int BOOT_W = $clog2(STARTUP_SAMPLES + 1);
  localparam int PACK_W = $clog2(SEED_SAMPLES + 1);
  localparam int POS_W  = $clog2(APT_WINDOW);
  localparam int RUN_W  = $clog2(RCT_CUTOFF + 1);
  localparam int HIT_W  = $clog2(APT_CUTOFF + 1);

  localparam logic [BOOT_W-1:0] BOOT_LAST = BOOT_W'(STARTUP_SAMPLES - 1);
  localparam logic [PACK_W-1:0] PACK_LAST = PACK_W'(SEED_SAMPLES - 1);
  localparam logic [POS_W-1:0]  POS_LAST  = POS_W'(APT_WINDOW - 1);
  localparam logic [RUN_W-1:0]  RUN_LIM   = RUN_W'(RCT_CUTOFF);
  localparam logic [HIT_W-1:0]  HIT_LIM   = HIT_W'(APT_CUTOFF);

  logic [SAMPLE_W-1:0] last_smp, apt_ref;
  logic [RUN_W-1:0]    rct_run, rct_next;
  logic [POS_W-1:0]    apt_pos;
  logic [HIT_W-1:0]    apt_hits, apt_next;
  logic [BOOT_W-1:0]   boot_cnt;
  logic [PACK_W-1:0]   pack_cnt;
  logic [SEED_W-1:0]   seed_q;
  logic                qual_q, fail_q, rdy_q;
  logic                rct_same, apt_first, test_fail, take, last_nib;

  assign rct_same  = (rct_run != '0) && (smp_i == last_smp);
  assign rct_next  = !rct_same ? RUN_W'(1) :
                     (rct_run == RUN_LIM) ? rct_run : rct_run + 1'b1;
  assign apt_first = (apt_pos == '0);
  assign apt_next  = apt_first ? HIT_W'(1) :
                     (smp_i == apt_ref && apt_hits != HIT_LIM) ? apt_hits + 1'b1 : apt_hits;
  assign test_fail = smp_valid_i && (rct_next >= RUN_LIM || apt_next >= HIT_LIM);
  assign take      = smp_valid_i && qual_q && !rdy_q && !fail_q;
  assign last_nib  = take && (pack_cnt == PACK_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_smp <= '0;
      apt_ref  <= '0;
      rct_run  <= '0;
      apt_pos  <= '0;
      apt_hits <= '0;
      boot_cnt <= '0;
      pack_cnt <= '0;
      seed_q   <= '0;
      qual_q   <= 1'b0;
      fail_q   <= 1'b0;
      rdy_q    <= 1'b0;
    end else begin
      if (smp_valid_i) begin
        last_smp <= smp_i;
        rct_run  <= rct_next;
        apt_hits <= apt_next;
        apt_pos  <= (apt_pos == POS_LAST) ? '0 : apt_pos + 1'b1;
        if (apt_first) apt_ref <= smp_i;
        if (!qual_q) begin
          boot_cnt <= boot_cnt + 1'b1;
          if (boot_cnt == BOOT_LAST && !test_fail && !fail_q) qual_q <= 1'b1;
        end
      end
      if (test_fail) fail_q <= 1'b1;
      if (rdy_q && seed_ack_i) begin
        rdy_q    <= 1'b0;
        pack_cnt <= '0;
        seed_q   <= '0;
      end else if (take) begin
        seed_q   <= {seed_q[SEED_W-SAMPLE_W-1:0], smp_i};
        pack_cnt <= pack_cnt + 1'b1;
        if (last_nib && !test_fail) rdy_q <= 1'b1;
      end
    end
  end

  assign perm_fail_o  = fail_q;
  assign qualified_o  = qual_q && !fail_q;
  assign seed_ready_o = rdy_q && !fail_q;
  assign seed_o       = seed_ready_o ? seed_q : '0;

endmodule

// File: rtl/entropy_seed_collector_chk.sv
module entropy_seed_collector_chk #(
  parameter int SEED_W = 2560
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_valid_i,
  input logic              seed_ack_i,
  input logic              seed_ready_o,
  input logic [SEED_W-1:0] seed_o,
  input logic              qualified_o,
  input logic              perm_fail_o
);

  a_r5_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    perm_fail_o |=> perm_fail_o);

  a_r5_no_qual_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
    perm_fail_o |-> !qualified_o);

  a_r6_no_seed_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
    perm_fail_o |-> (!seed_ready_o && seed_o == '0));

  a_r4_ready_needs_qual: assert property (@(posedge clk) disable iff (!rst_n)
    seed_ready_o |-> qualified_o);

  a_r4_qual_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(qualified_o) |-> $past(smp_valid_i));

  a_r7_ready_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seed_ready_o) |-> $past(smp_valid_i));

  a_r8_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_ready_o && !seed_ack_i) |=> (seed_ready_o || perm_fail_o));

  a_r8_seed_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_ready_o && !seed_ack_i) |=> (!seed_ready_o || $stable(seed_o)));

  a_r8_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_ready_o && seed_ack_i) |=> !seed_ready_o);

endmodule

bind entropy_seed_collector entropy_seed_collector_chk #(.SEED_W(SEED_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid_i(smp_valid_i), .seed_ack_i(seed_ack_i),
  .seed_ready_o(seed_ready_o), .seed_o(seed_o), .qualified_o(qualified_o),
  .perm_fail_o(perm_fail_o)
);

// File: tb/test_entropy_seed_collector.sv
module test_entropy_seed_collector;
  localparam int SW = 4, NSEED = 640, NBOOT = 1024, WIN = 512, RCT = 8, APT = 100;
  localparam int SEED_W = SW * NSEED;

  logic clk = 1'b0, rst_n = 1'b0, smp_valid_i = 1'b0, seed_ack_i = 1'b0;
  logic [SW-1:0] smp_i = '0;
  logic seed_ready_o, qualified_o, perm_fail_o;
  logic [SEED_W-1:0] seed_o;

  always #2.5 clk = ~clk;

  entropy_seed_collector #(.SAMPLE_W(SW), .SEED_SAMPLES(NSEED), .STARTUP_SAMPLES(NBOOT),
    .APT_WINDOW(WIN), .RCT_CUTOFF(RCT), .APT_CUTOFF(APT)) i_entropy_seed_collector (
    .clk(clk), .rst_n(rst_n), .smp_valid_i(smp_valid_i), .smp_i(smp_i),
    .seed_ack_i(seed_ack_i), .seed_ready_o(seed_ready_o), .seed_o(seed_o),
    .qualified_o(qualified_o), .perm_fail_o(perm_fail_o));

  int ntot = 0, nfail = 0;
  bit done = 0;

  logic [SW-1:0] m_prev, m_ref, m_first;
  int m_run, m_idx, m_hits, m_boot, m_nst;
  bit m_qual, m_fail, m_rdy;
  logic [SEED_W-1:0] m_seed;

  task automatic chk(input bit ok, input string msg);
    ntot++;
    if (!ok) begin nfail++; $display("FAIL %s", msg); end
  endtask

  task automatic model_reset();
    m_prev = '0; m_ref = '0; m_first = '0; m_run = 0; m_idx = 0; m_hits = 0;
    m_boot = 0; m_nst = 0; m_qual = 0; m_fail = 0; m_rdy = 0; m_seed = '0;
  endtask

  task automatic model_step(input bit v, input logic [SW-1:0] n, input bit a);
    bit bad = 0;
    bit rdy_before = m_rdy;
    if (v) begin
      m_run = (m_run != 0 && n == m_prev) ? m_run + 1 : 1;
      m_prev = n;
      if (m_run >= RCT) bad = 1;
      if (m_idx == 0) begin m_ref = n; m_hits = 1; end
      else if (n == m_ref) m_hits++;
      if (m_hits >= APT) bad = 1;
      m_idx = (m_idx == WIN - 1) ? 0 : m_idx + 1;
      if (!m_qual) begin
        m_boot++;
        if (m_boot == NBOOT && !bad && !m_fail) m_qual = 1;
      end else if (!rdy_before && !m_fail) begin
        if (m_nst == 0) m_first = n;
        m_seed = {m_seed[SEED_W-SW-1:0], n};
        m_nst++;
        if (m_nst == NSEED && !bad) m_rdy = 1;
      end
    end
    if (rdy_before && a) begin m_rdy = 0; m_nst = 0; m_seed = '0; end
    if (bad) m_fail = 1;
  endtask

  task automatic step(input bit v, input logic [SW-1:0] n, input bit a);
    logic [SEED_W-1:0] es;
    smp_valid_i = v; smp_i = n; seed_ack_i = a;
    @(posedge clk);
    model_step(v, n, a);
    @(negedge clk);
    smp_valid_i = 0; seed_ack_i = 0;
    es = (m_rdy && !m_fail) ? m_seed : '0;
    chk(perm_fail_o == m_fail, $sformatf("R5 fail flag act=%0b exp=%0b", perm_fail_o, m_fail));
    chk(qualified_o == (m_qual && !m_fail), $sformatf("R4 qualified act=%0b exp=%0b", qualified_o, m_qual && !m_fail));
    chk(seed_ready_o == (m_rdy && !m_fail), $sformatf("R7 ready act=%0b exp=%0b", seed_ready_o, m_rdy && !m_fail));
    chk(seed_o == es, $sformatf("R7 seed act=%h exp=%h", seed_o, es));
  endtask

  function automatic logic [SW-1:0] rnd_nib();
    logic [SW-1:0] n = SW'($urandom % 16);
    if (m_run >= 3 && n == m_prev) n = n + 1'b1;
    return n;
  endfunction

  task automatic send_rand(input int cnt);
    for (int i = 0; i < cnt; i++) begin
      if ($urandom % 4 == 0) step(0, SW'($urandom % 16), 0);
      step(1, rnd_nib(), 0);
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    @(posedge clk); @(negedge clk);
    model_reset();
    chk(seed_o == '0 && !seed_ready_o && !qualified_o && !perm_fail_o,
        $sformatf("R9 reset clears act rdy=%0b q=%0b f=%0b exp 0", seed_ready_o, qualified_o, perm_fail_o));
    rst_n = 1;
    step(0, '0, 0);
  endtask

  task automatic align_window();
    while (m_idx != 0) step(1, rnd_nib(), 0);
  endtask

  initial begin
    logic [SEED_W-1:0] held;
    logic [SW-1:0] x;
    int xs;
    void'($urandom(32'h5eed_0042));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!seed_ready_o && !qualified_o && !perm_fail_o && seed_o == '0,
        $sformatf("R1 in reset act rdy=%0b q=%0b f=%0b exp 0", seed_ready_o, qualified_o, perm_fail_o));
    rst_n = 1;
    step(0, '0, 0);
    chk(!seed_ready_o && !qualified_o && !perm_fail_o, "R1 after release act nonzero exp 0");

    send_rand(NBOOT - 1);
    chk(!qualified_o, $sformatf("R4 one sample short act=%0b exp=0", qualified_o));
    send_rand(1);
    chk(qualified_o, $sformatf("R4 after startup run act=%0b exp=1", qualified_o));

    send_rand(NSEED - 1);
    chk(!seed_ready_o, $sformatf("R7 one nibble short act=%0b exp=0", seed_ready_o));
    send_rand(1);
    chk(seed_ready_o, $sformatf("R7 seed complete act=%0b exp=1", seed_ready_o));
    chk(seed_o[SEED_W-1 -: SW] == m_first,
        $sformatf("R7 first nibble on top act=%h exp=%h", seed_o[SEED_W-1 -: SW], m_first));

    held = seed_o;
    for (int i = 0; i < 30; i++) step($urandom % 2, rnd_nib(), 0);
    chk(seed_ready_o && seed_o == held, $sformatf("R8 seed held act rdy=%0b exp 1", seed_ready_o));
    step(1, rnd_nib(), 1);
    chk(!seed_ready_o, $sformatf("R8 ack drops ready act=%0b exp=0", seed_ready_o));
    send_rand(NSEED);
    chk(seed_ready_o && seed_o == m_seed, "R8 next seed from post-ack samples mismatch");

    for (int k = 0; k < 3; k++) begin
      for (int w = 0; w < int'($urandom % 20); w++) step($urandom % 2, rnd_nib(), 0);
      step($urandom % 2, rnd_nib(), 1);
      send_rand(NSEED);
      chk(seed_ready_o && seed_o == m_seed, $sformatf("R7 random seed %0d mismatch", k));
    end
    step(0, '0, 1);

    x = m_prev + 4'd5;
    for (int i = 0; i < RCT - 1; i++) step(1, x, 0);
    chk(!perm_fail_o, $sformatf("R2 run one short act=%0b exp=0", perm_fail_o));

    align_window();
    x = rnd_nib();
    xs = 0;
    for (int i = 0; i < WIN; i++) begin
      if (i % 2 == 0 && xs < APT - 1) begin step(1, x, 0); xs++; end
      else step(1, x + SW'(1 + i % 15), 0);
    end
    chk(!perm_fail_o, $sformatf("R3 window one short act=%0b exp=0", perm_fail_o));

    do_reset();
    send_rand(NBOOT);
    align_window();
    x = rnd_nib();
    xs = 0;
    for (int i = 0; xs < APT; i++) begin
      if (i % 2 == 0) begin
        if (xs == APT - 1) chk(!perm_fail_o, $sformatf("R3 before cutoff act=%0b exp=0", perm_fail_o));
        step(1, x, 0); xs++;
      end else step(1, x + SW'(1 + i % 15), 0);
    end
    chk(perm_fail_o, $sformatf("R3 cutoff reached act=%0b exp=1", perm_fail_o));
    send_rand(NSEED + 60);
    chk(perm_fail_o && !qualified_o, $sformatf("R5 sticky act f=%0b q=%0b exp 1 0", perm_fail_o, qualified_o));
    chk(!seed_ready_o && seed_o == '0, $sformatf("R6 no seed after fail act=%0b exp=0", seed_ready_o));

    do_reset();
    send_rand(NBOOT + NSEED);
    chk(seed_ready_o, $sformatf("R9 requalified seed act=%0b exp=1", seed_ready_o));
    x = m_prev + 4'd3;
    for (int i = 0; i < RCT - 1; i++) step(1, x, 0);
    chk(!perm_fail_o && seed_ready_o, "R2 seven repeats must not fail");
    step(1, x, 0);
    chk(perm_fail_o, $sformatf("R2 run reaches cutoff act=%0b exp=1", perm_fail_o));
    chk(!seed_ready_o && seed_o == '0, $sformatf("R6 pending seed withdrawn act=%0b exp=0", seed_ready_o));
    step(0, '0, 1);
    send_rand(NSEED + 10);
    chk(!seed_ready_o && perm_fail_o, $sformatf("R6 no new seed act=%0b exp=0", seed_ready_o));

    done = 1;
    $display("%0d/%0d checks passed", ntot - nfail, ntot);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(0, "R1 watchdog expired act=running exp=done");
      $display("%0d/%0d checks passed", ntot - nfail, ntot);
      $finish;
    end
  end
endmodule